// File: doc/BRIEF.md
# Serial Boot Command Detector

This block listens to a single-bit command line that a host clocks while it waits to start a boot transfer. The line rests high and the host clock runs freely long before any command, so the receiver sees a long stream of ones. The detector hunts for the first zero in that stream and takes it as the first bit of a 48-bit command frame. It collects the remaining 47 bits and compares the whole word against three fixed boot-mode frames.

Every completed frame produces a one-cycle valid pulse together with a two-bit code. The code names the frame as go-idle, go-pre-idle or boot-initiation, or reports an error when the word matches none of them. The block runs in the system clock domain. A sampled clock enable marks the cycles that carry a line bit, and an enable input throws away any partial frame.

Top module: `boot_cmd_detector`

## Requirements
- R1: After reset, frame_valid is 0 and frame_code holds the error code 2'b11.
- R2: While hunting, a 1 on cmd_bit is ignored: no frame starts and no valid pulse appears, however long the run of ones.
- R3: The first 0 sampled while hunting becomes the most significant bit of a 48-bit frame. The next 47 sampled bits follow in order, most significant first.
- R4: The frame 0x400000000095 is reported with code 2'b00 (go-idle).
- R5: The frame 0x40F0F0F0F0FD is reported with code 2'b01 (go-pre-idle).
- R6: The frame 0x40FFFFFFFAE5 is reported with code 2'b10 (boot-initiation).
- R7: Any other complete 48-bit frame is reported with code 2'b11 (error).
- R8: frame_valid is high for exactly one cycle, namely the cycle after the clock edge that samples the 48th bit. frame_code then keeps its value until the next valid pulse.
- R9: In a cycle where bit_en is 0, cmd_bit is not sampled and the frame does not advance.
- R10: While enable is 0, the partial frame is discarded and no valid pulse is produced. When enable returns, the block hunts for a fresh 0.
- R11: Once a frame completes, the block hunts again at once, so a 0 in the very next sampled bit starts a new frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Detector enable; low clears any partial frame |
| bit_en | input | 1 | Sampled host clock strobe: high when cmd_bit carries a line bit |
| cmd_bit | input | 1 | Command line level |
| frame_valid | output | 1 | One-cycle pulse per completed frame |
| frame_code | output | 2 | 00 go-idle, 01 go-pre-idle, 10 boot-initiation, 11 error |

## Verification
The decoded result has exactly one register of delay. The valid pulse and its code appear in the cycle right after the edge that samples the 48th strobed bit, and at no other time. The bench drives each bit at a falling edge and samples the outputs at the following falling edge. In that way every strobe cycle, gap cycle and disabled cycle is checked for the absence of a pulse, and the final bit is checked for its presence and its code. Between pulses, the code is checked again after trailing ones to confirm that it holds.

// File: rtl/cmd_det_pkg.sv
package cmd_det_pkg;
   typedef enum logic [1:0] {
      CODE_IDLE     = 2'b00,
      CODE_PRE_IDLE = 2'b01,
      CODE_BOOT     = 2'b10,
      CODE_ERROR    = 2'b11
   } cmd_code_t;

   typedef enum logic {
      ST_HUNT,
      ST_CAPTURE
   } hunt_state_t;
endpackage

// File: rtl/cmd_frame_hunter.sv
module cmd_frame_hunter #(
   parameter int FRAME_BITS = 48,
   localparam int CNT_W = $clog2(FRAME_BITS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic             strobe,
   input  logic             line_bit,
   output logic             shift_en,
   output logic             frame_done,
   output logic [CNT_W-1:0] bit_cnt
);
   import cmd_det_pkg::*;

   localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS - 1);

   hunt_state_t state_q;
   logic [CNT_W-1:0] cnt_q;
   logic at_last;

   assign at_last    = (state_q == ST_CAPTURE) && (cnt_q == LAST_CNT);
   assign shift_en   = enable && strobe && ((state_q == ST_CAPTURE) || !line_bit);
   assign frame_done = enable && strobe && at_last;
   assign bit_cnt    = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || !enable) begin
         state_q <= ST_HUNT;
         cnt_q   <= '0;
      end else if (strobe) begin
         unique case (state_q)
            ST_HUNT: begin
               if (!line_bit) begin
                  state_q <= ST_CAPTURE;
                  cnt_q   <= CNT_W'(1);
               end
            end
            ST_CAPTURE: begin
               if (at_last) begin
                  state_q <= ST_HUNT;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CNT_W'(1);
               end
            end
            default: begin
               state_q <= ST_HUNT;
               cnt_q   <= '0;
            end
         endcase
      end
   end
endmodule

// File: rtl/cmd_frame_shifter.sv
module cmd_frame_shifter #(
   parameter int FRAME_BITS = 48
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  shift_en,
   input  logic                  line_bit,
   output logic [FRAME_BITS-1:0] frame_word
);
   logic [FRAME_BITS-2:0] shreg_q;

   assign frame_word = {shreg_q, line_bit};

   always_ff @(posedge clk) begin
      if (!rst_n)
         shreg_q <= '1;
      else if (shift_en)
         shreg_q <= {shreg_q[FRAME_BITS-3:0], line_bit};
   end
endmodule

// File: rtl/cmd_pattern_match.sv
module cmd_pattern_match #(
   parameter int FRAME_BITS = 48,
   parameter logic [FRAME_BITS-1:0] PAT_IDLE = '0,
   parameter logic [FRAME_BITS-1:0] PAT_PRE  = '0,
   parameter logic [FRAME_BITS-1:0] PAT_BOOT = '0,
   localparam int NUM_PATS = 3
) (
   input  logic [FRAME_BITS-1:0] frame_word,
   output cmd_det_pkg::cmd_code_t code
);
   import cmd_det_pkg::*;

   localparam logic [NUM_PATS*FRAME_BITS-1:0] PATS = {PAT_BOOT, PAT_PRE, PAT_IDLE};

   logic [NUM_PATS-1:0] hit;

   for (genvar k = 0; k < NUM_PATS; k++) begin : g_cmp
      assign hit[k] = (frame_word == PATS[k*FRAME_BITS +: FRAME_BITS]);
   end

   always_comb begin
      if (hit[0])
         code = CODE_IDLE;
      else if (hit[1])
         code = CODE_PRE_IDLE;
      else if (hit[2])
         code = CODE_BOOT;
      else
         code = CODE_ERROR;
   end
endmodule

// File: rtl/boot_cmd_detector.sv
module boot_cmd_detector #(
   parameter int FRAME_BITS = 48,
   parameter logic [FRAME_BITS-1:0] PAT_IDLE = 48'h4000_0000_0095,
   parameter logic [FRAME_BITS-1:0] PAT_PRE  = 48'h40F0_F0F0_F0FD,
   parameter logic [FRAME_BITS-1:0] PAT_BOOT = 48'h40FF_FFFF_FAE5,
   parameter bit USE_BIT_EN = 1'b1,
   localparam int CNT_W = $clog2(FRAME_BITS)
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       bit_en,
   input  logic       cmd_bit,
   output logic       frame_valid,
   output logic [1:0] frame_code
);
   import cmd_det_pkg::*;

   if (FRAME_BITS < 3) begin : g_bad_len
      $error("FRAME_BITS must be at least 3");
   end
   if (PAT_IDLE == PAT_PRE || PAT_IDLE == PAT_BOOT || PAT_PRE == PAT_BOOT) begin : g_bad_pat
      $error("command patterns must be distinct");
   end
   if (PAT_IDLE[FRAME_BITS-1] || PAT_PRE[FRAME_BITS-1] || PAT_BOOT[FRAME_BITS-1]) begin : g_bad_msb
      $error("every pattern must start with 0 to be alignable");
   end

   logic bit_strobe;
   if (USE_BIT_EN) begin : g_strobe_en
      assign bit_strobe = bit_en;
   end else begin : g_strobe_free
      assign bit_strobe = 1'b1;
   end

   logic             shift_en;
   logic             frame_done;
   logic [CNT_W-1:0] hunt_cnt;
   logic [FRAME_BITS-1:0] frame_word;
   cmd_code_t        match_code;
   logic             valid_q;
   cmd_code_t        code_q;

   cmd_frame_hunter #(.FRAME_BITS(FRAME_BITS)) hunter_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (enable),
      .strobe     (bit_strobe),
      .line_bit   (cmd_bit),
      .shift_en   (shift_en),
      .frame_done (frame_done),
      .bit_cnt    (hunt_cnt)
   );

   cmd_frame_shifter #(.FRAME_BITS(FRAME_BITS)) shifter_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en   (shift_en),
      .line_bit   (cmd_bit),
      .frame_word (frame_word)
   );

   cmd_pattern_match #(
      .FRAME_BITS (FRAME_BITS),
      .PAT_IDLE   (PAT_IDLE),
      .PAT_PRE    (PAT_PRE),
      .PAT_BOOT   (PAT_BOOT)
   ) match_i (
      .frame_word (frame_word),
      .code       (match_code)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         code_q  <= CODE_ERROR;
      end else begin
         valid_q <= frame_done;
         if (frame_done)
            code_q <= match_code;
      end
   end

   assign frame_valid = valid_q;
   assign frame_code  = code_q;
endmodule

// File: rtl/boot_cmd_detector_checker.sv
module boot_cmd_detector_checker #(
   parameter int FRAME_BITS = 48,
   localparam int CNT_W = $clog2(FRAME_BITS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             enable,
   input logic             strobe,
   input logic             frame_valid,
   input logic [1:0]       frame_code,
   input logic [CNT_W-1:0] hunt_cnt
);
   assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid);

   assert_code_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_valid |-> $stable(frame_code));

   assert_valid_needs_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |-> $past(strobe && enable));

   assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(enable) |-> (!frame_valid && hunt_cnt == '0));

   assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hunt_cnt <= CNT_W'(FRAME_BITS - 1));
endmodule

bind boot_cmd_detector boot_cmd_detector_checker #(.FRAME_BITS(FRAME_BITS)) chk_i (
   .clk         (clk),
   .rst_n       (rst_n),
   .enable      (enable),
   .strobe      (bit_strobe),
   .frame_valid (frame_valid),
   .frame_code  (frame_code),
   .hunt_cnt    (hunt_cnt)
);

// File: tb/boot_cmd_detector_tb.sv
module boot_cmd_detector_tb_top;
   localparam logic [47:0] F_IDLE = 48'h4000_0000_0095;
   localparam logic [47:0] F_PRE  = 48'h40F0_F0F0_F0FD;
   localparam logic [47:0] F_BOOT = 48'h40FF_FFFF_FAE5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic enable = 1'b0;
   logic bit_en = 1'b0;
   logic cmd_bit = 1'b1;
   logic frame_valid;
   logic [1:0] frame_code;

   int checks = 0;
   int fails = 0;
   int stray = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   boot_cmd_detector dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable), .bit_en(bit_en),
      .cmd_bit(cmd_bit), .frame_valid(frame_valid), .frame_code(frame_code)
   );

   function automatic logic [1:0] expect_code(logic [47:0] f);
      if (f == F_IDLE) return 2'b00;
      if (f == F_PRE)  return 2'b01;
      if (f == F_BOOT) return 2'b10;
      return 2'b11;
   endfunction

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // drive at falling edge, return outputs sampled at the next falling edge
   task automatic cycle(input logic en, input logic b, output logic v, output logic [1:0] c);
      bit_en  = en;
      cmd_bit = b;
      @(posedge clk);
      @(negedge clk);
      v = frame_valid;
      c = frame_code;
   endtask

   // one strobed bit, with an optional random gap of unstrobed cycles first (R9)
   task automatic send_bit(input logic b, input int max_gap, output logic v, output logic [1:0] c);
      int gap = (max_gap > 0) ? int'($urandom_range(max_gap, 0)) : 0;
      for (int g = 0; g < gap; g++) begin
         cycle(1'b0, 1'($urandom), v, c);
         if (v) stray++;
      end
      cycle(1'b1, b, v, c);
   endtask

   task automatic send_ones(input int n, input string req);
      logic v;
      logic [1:0] c;
      int seen = 0;
      for (int i = 0; i < n; i++) begin
         send_bit(1'b1, 0, v, c);
         if (v) seen++;
      end
      check(req, seen, 0);
   endtask

   task automatic send_frame(input logic [47:0] f, input int max_gap, input string req);
      logic v;
      logic [1:0] c;
      int early = 0;
      stray = 0;
      for (int i = 47; i > 0; i--) begin
         send_bit(f[i], max_gap, v, c);
         if (v) early++;
      end
      check({req, " no early pulse"}, early + stray, 0);
      send_bit(f[0], max_gap, v, c);
      check({req, " pulse R8"}, v, 1);
      check({req, " code"}, c, expect_code(f));
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         fails++;
         checks++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      logic v;
      logic [1:0] c;
      void'($urandom(32'h5EED_1234));
      repeat (3) @(negedge clk);
      check("R1 valid after reset", frame_valid, 0);
      check("R1 code after reset", frame_code, 2'b11);
      rst_n  = 1'b1;
      enable = 1'b1;

      send_ones(200, "R2 long idle run");
      send_frame(F_IDLE, 0, "R4 go-idle");
      send_ones(5, "R2 between frames");
      check("R8 code holds", frame_code, 2'b00);
      send_frame(F_PRE, 0, "R5 go-pre-idle");
      send_ones(13, "R2");
      send_frame(F_BOOT, 0, "R6 boot-init R3");

      // gaps between strobes
      send_ones(7, "R2");
      send_frame(F_BOOT, 3, "R9 gapped boot");
      send_frame(F_IDLE, 2, "R11 back-to-back R9");

      // random idle runs and corrupted frames
      for (int t = 0; t < 24; t++) begin
         logic [47:0] f;
         int sel = int'($urandom_range(3, 0));
         send_ones(int'($urandom_range(40, 1)), "R2 random idle");
         f = (sel == 0) ? F_IDLE : (sel == 1) ? F_PRE : F_BOOT;
         if (sel == 3) f[$urandom_range(46, 0)] ^= 1'b1;
         send_frame(f, (t % 3 == 0) ? 2 : 0, (sel == 3) ? "R7 corrupted" : "R3 random valid");
      end

      // R7 error code on an all-zero frame
      send_frame(48'h0, 0, "R7 zero frame");

      // R10: abort partial frame
      for (int i = 47; i > 27; i--) send_bit(F_BOOT[i], 0, v, c);
      enable = 1'b0;
      stray  = 0;
      for (int i = 0; i < 4; i++) begin
         cycle(1'b1, 1'b0, v, c);
         if (v) stray++;
      end
      check("R10 no pulse while disabled", stray, 0);
      enable = 1'b1;
      send_ones(30, "R10 old partial not resumed");
      send_frame(F_PRE, 0, "R10 fresh frame after enable");
      send_ones(3, "R2");
      check("R8 code holds after ones", frame_code, 2'b01);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule